// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block is the front end of a small interrupt controller serving a parameterised number of request lines, eight by default. A rising level on a request line latches that line's pending flag. A per-line enable mask decides whether a pending line is eligible. One designated line is non-maskable and is eligible whenever it is pending, whatever its enable flag holds. From the eligible lines the block picks one in a fixed order and presents it to the processor as a request with a line number.

When the processor acknowledges entry, the chosen line moves from pending to active. The block then reports the line number for loading into the processor status register. No further request is raised while any line is active. A return strobe naming a line ends that line's active state.

Software drives four set/clear masks, which act on the pending flags and the enable flags. All state and every output are registers, reset synchronously.

Top module: `irq_pend_act_ctrl`

## Requirements
- R1: After reset, the pending, enable and active vectors are all zero. The request output, the entry pulse and the status line number are also zero.
- R2: When a request line goes from 0 to 1 between two clock edges, that line's pending bit is 1 after the edge. A request line held high sets pending only once.
- R3: A bit set in the software pending-clear mask clears that pending bit at the next edge. This clear wins over a software set, a rising request and a held state in the same cycle.
- R4: A bit in the enable-set mask sets that enable bit, and a bit in the enable-clear mask clears it. When both are given in the same cycle, the clear wins.
- R5: A maskable line is eligible only while it is both pending and enabled. The non-maskable line, index NMI_LINE (default 7), is eligible while pending, whatever its enable bit holds.
- R6: Among eligible lines, NMI_LINE is chosen first; otherwise the lowest-numbered eligible line is chosen.
- R7: The request output is 1 exactly when some line is eligible and no active bit is set. The line-number output then holds the chosen line. Both outputs reflect the state present in the same cycle.
- R8: An acknowledge given while the request output is 1 takes effect at the next edge. It clears the presented line's pending bit and sets its active bit. It loads the line number into the status output and raises the entry pulse for one cycle.
- R9: An acknowledge given while the request output is 0 changes nothing.
- R10: A return strobe clears the active bit of the line it names at the next edge. If an entry happens in the same cycle, the entry's active set wins.
- R11: A pending bit that is not cleared by software stays set until that line is entered, even while it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | NUM_LINES | Request levels, edge-detected |
| sw_pend_set | input | NUM_LINES | Software mask that sets pending bits |
| sw_pend_clr | input | NUM_LINES | Software mask that clears pending bits |
| sw_en_set | input | NUM_LINES | Software mask that sets enable bits |
| sw_en_clr | input | NUM_LINES | Software mask that clears enable bits |
| cpu_ack | input | 1 | Handler entry acknowledge |
| cpu_ret | input | 1 | Handler return strobe |
| cpu_ret_line | input | IDX_W | Line whose active bit the return clears |
| irq_req | output | 1 | Request to the processor |
| irq_line | output | IDX_W | Line presented with the request |
| entry_pulse | output | 1 | One-cycle pulse after an accepted entry |
| status_line | output | IDX_W | Line number for the status register |
| pending | output | NUM_LINES | Pending flags |
| enable | output | NUM_LINES | Enable flags |
| active | output | NUM_LINES | Active flags |

## Verification
Every input change takes effect at the next rising edge. At that edge the pending, enable and active vectors, the request and line outputs, the entry pulse and the status line all update together, which gives a latency of one cycle. An acknowledge refers to the request and line values that were visible in the cycle it was asserted. The bench drives inputs just after a falling edge and advances its reference model at the rising edge. It compares every output at the following falling edge, so each result is sampled exactly one edge after its stimulus. A directed prologue covers the ordering and clear-wins cases, and a long pseudo-random phase follows it.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  localparam int MAX_LINES = 32;

  // index of the lowest set bit among the first n bits, or -1 when none is set
  function automatic int lowest_set(input logic [MAX_LINES-1:0] v, input int n);
    int r;
    r = -1;
    for (int i = MAX_LINES - 1; i >= 0; i--) begin
      if (i < n && v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lvl,
  output logic [NUM_LINES-1:0] rise
);

  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/irq_line_state.sv
module irq_line_state #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rise,
  input  logic [NUM_LINES-1:0] sw_pend_set,
  input  logic [NUM_LINES-1:0] sw_pend_clr,
  input  logic [NUM_LINES-1:0] sw_en_set,
  input  logic [NUM_LINES-1:0] sw_en_clr,
  input  logic                 take,
  input  logic [IDX_W-1:0]     take_idx,
  input  logic                 ret,
  input  logic [IDX_W-1:0]     ret_idx,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] act_q,
  output logic [NUM_LINES-1:0] pend_d,
  output logic [NUM_LINES-1:0] en_d,
  output logic [NUM_LINES-1:0] act_d
);

  logic [NUM_LINES-1:0] take_mask;
  logic [NUM_LINES-1:0] ret_mask;

  // one-hot decode of the entered and the returning line
  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
      assign take_mask[g] = take && (take_idx == IDX_W'(g));
      assign ret_mask[g]  = ret  && (ret_idx  == IDX_W'(g));
    end
  endgenerate

  // clears win over every set source; entry removes the pending bit
  assign pend_d = (pend_q | rise | sw_pend_set) & ~sw_pend_clr & ~take_mask;
  assign en_d   = (en_q | sw_en_set) & ~sw_en_clr;
  // return is applied first, so an entry in the same cycle wins
  assign act_d  = (act_q & ~ret_mask) | take_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      act_q  <= act_d;
    end
  end

  // R3: a software clear always leaves the bit clear
  p_swclr_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_pend_clr != '0) |=> ((pend_q & $past(sw_pend_clr)) == '0));

  // R4: an enable clear always leaves the bit clear
  p_enclr_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_en_clr != '0) |=> ((en_q & $past(sw_en_clr)) == '0));

  // R2: a rising request without a clear leaves the line pending or entered
  p_rise_latched_r2: assert property (@(posedge clk) disable iff (rst)
    ((rise & ~sw_pend_clr) != '0) |=>
      (((pend_q | act_q) & $past(rise & ~sw_pend_clr)) == $past(rise & ~sw_pend_clr)));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_trk_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NMI_LINE  = 7,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] en,
  input  logic [NUM_LINES-1:0] act,
  output logic                 req,
  output logic [IDX_W-1:0]     idx
);

  localparam logic [NUM_LINES-1:0] NMI_MASK = NUM_LINES'(1) << NMI_LINE;

  logic [NUM_LINES-1:0] elig;
  int                   low;

  assign elig = pend & (en | NMI_MASK);

  always_comb begin
    low = lowest_set(MAX_LINES'(elig), NUM_LINES);
    req = (act == '0) && (elig != '0);
    if (elig[NMI_LINE])  idx = IDX_W'(NMI_LINE);
    else if (low >= 0)   idx = IDX_W'(low);
    else                 idx = '0;
  end

endmodule

// File: rtl/irq_pend_act_ctrl.sv
module irq_pend_act_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int NMI_LINE  = 7,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lvl,
  input  logic [NUM_LINES-1:0] sw_pend_set,
  input  logic [NUM_LINES-1:0] sw_pend_clr,
  input  logic [NUM_LINES-1:0] sw_en_set,
  input  logic [NUM_LINES-1:0] sw_en_clr,
  input  logic                 cpu_ack,
  input  logic                 cpu_ret,
  input  logic [IDX_W-1:0]     cpu_ret_line,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     irq_line,
  output logic                 entry_pulse,
  output logic [IDX_W-1:0]     status_line,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] enable,
  output logic [NUM_LINES-1:0] active
);

  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] pend_d, en_d, act_d;
  logic                 take;
  logic                 req_d;
  logic [IDX_W-1:0]     idx_d;
  logic                 req_q, entry_q;
  logic [IDX_W-1:0]     line_q, stat_q;

  // only an acknowledge that meets a live request is an entry
  assign take = cpu_ack && req_q;

  irq_edge_det #(.NUM_LINES(NUM_LINES)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  (irq_lvl),
    .rise (rise)
  );

  irq_line_state #(.NUM_LINES(NUM_LINES)) state_i (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .sw_pend_set (sw_pend_set),
    .sw_pend_clr (sw_pend_clr),
    .sw_en_set   (sw_en_set),
    .sw_en_clr   (sw_en_clr),
    .take        (take),
    .take_idx    (line_q),
    .ret         (cpu_ret),
    .ret_idx     (cpu_ret_line),
    .pend_q      (pending),
    .en_q        (enable),
    .act_q       (active),
    .pend_d      (pend_d),
    .en_d        (en_d),
    .act_d       (act_d)
  );

  // selection runs on next-state values so the registered request matches the flags
  irq_pick #(.NUM_LINES(NUM_LINES), .NMI_LINE(NMI_LINE)) pick_i (
    .pend (pend_d),
    .en   (en_d),
    .act  (act_d),
    .req  (req_d),
    .idx  (idx_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      line_q  <= '0;
      entry_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      req_q   <= req_d;
      line_q  <= idx_d;
      entry_q <= take;
      if (take) stat_q <= line_q;
    end
  end

  assign irq_req     = req_q;
  assign irq_line    = line_q;
  assign entry_pulse = entry_q;
  assign status_line = stat_q;

  // R7: no request while a handler is active
  p_req_idle_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (active == '0));

  // R7: the presented line is actually pending
  p_req_line_pending_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> pending[irq_line]);

  // R6: the non-maskable line is presented first
  p_nmi_first_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && pending[NMI_LINE]) |-> (irq_line == IDX_W'(NMI_LINE)));

  // R8: entry moves the line from pending to active and reports it
  p_entry_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_req) |=>
      (active[$past(irq_line)] && !pending[$past(irq_line)] &&
       entry_pulse && status_line == $past(irq_line)));

  // R8: at most one line is active
  p_one_active_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active));

  // R9: an acknowledge without a request produces no entry
  p_ack_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && !irq_req) |=> (!entry_pulse && $stable(status_line)));

  // R10: return clears the named active bit unless an entry happens together
  p_return_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_ret && !(cpu_ack && irq_req)) |=> !active[$past(cpu_ret_line)]);

endmodule

// File: tb/irq_pend_act_ctrl_tb_top.sv
module irq_pend_act_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int NMI = 7;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_lvl = '0, sps = '0, spc = '0, ses = '0, sec = '0;
  logic          ack = 1'b0, ret = 1'b0;
  logic [IW-1:0] ret_line = '0;
  logic          irq_req, entry_pulse;
  logic [IW-1:0] irq_line, status_line;
  logic [N-1:0]  pending, enable, active;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [N-1:0] m_prev = '0, m_pend = '0, m_en = '0, m_act = '0;
  logic         m_req = 0, m_entry = 0;
  int           m_line = 0, m_stat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_act_ctrl #(.NUM_LINES(N), .NMI_LINE(NMI)) dut_i (
    .clk(clk), .rst(rst), .irq_lvl(irq_lvl),
    .sw_pend_set(sps), .sw_pend_clr(spc), .sw_en_set(ses), .sw_en_clr(sec),
    .cpu_ack(ack), .cpu_ret(ret), .cpu_ret_line(ret_line),
    .irq_req(irq_req), .irq_line(irq_line), .entry_pulse(entry_pulse),
    .status_line(status_line), .pending(pending), .enable(enable), .active(active)
  );

  task automatic chk(input string tag, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic model_edge();
    bit take;
    int tl, best;
    take = ack && m_req;
    tl   = m_line;
    for (int i = 0; i < N; i++) begin
      bit r, p, e, a;
      r = irq_lvl[i] && !m_prev[i];
      m_prev[i] = irq_lvl[i];
      p = m_pend[i] || r || sps[i];
      if (spc[i]) p = 0;
      if (take && i == tl) p = 0;
      e = m_en[i] || ses[i];
      if (sec[i]) e = 0;
      a = m_act[i];
      if (ret && ret_line == i) a = 0;
      if (take && i == tl) a = 1;
      m_pend[i] = p; m_en[i] = e; m_act[i] = a;
    end
    m_entry = take;
    if (take) m_stat = tl;
    best = -1;
    if (m_pend[NMI]) best = NMI;
    else
      for (int i = N - 1; i >= 0; i--)
        if (m_pend[i] && m_en[i]) best = i;
    m_req = (m_act == '0) && (best >= 0);
    if (best >= 0) m_line = best;
  endtask

  task automatic compare();
    chk("R2/R3/R11 pending", pending, m_pend);
    chk("R4 enable", enable, m_en);
    chk("R8/R10 active", active, m_act);
    chk("R5/R7 irq_req", irq_req, m_req);
    if (m_req) chk("R6 irq_line", irq_line, m_line);
    chk("R8/R9 entry_pulse", entry_pulse, m_entry);
    chk("R8 status_line", status_line, m_stat);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    sps = '0; spc = '0; ses = '0; sec = '0; ack = 0; ret = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk("R1 pending", pending, 0);
    chk("R1 enable", enable, 0);
    chk("R1 active", active, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 entry_pulse", entry_pulse, 0);
    chk("R1 status_line", status_line, 0);

    // R2: rising edges on lines 2 and 5 while masked; R11 keeps them pending
    irq_lvl = 8'h24; step();
    idle(); step(); step();
    chk("R11 masked stays pending", pending, 8'h24);
    // R9: ack with no request
    ack = 1; step(); ack = 0;
    // R4: set enable of 5 and clear-wins on line 2
    ses = 8'h24; sec = 8'h04; step(); idle();
    chk("R5 only enabled line requested", irq_line, 5);
    // R3: clear wins over set and held edge
    sps = 8'h01; spc = 8'h01; step(); idle();
    chk("R3 clear wins", pending[0], 0);
    // R6: NMI pending while masked ranks first
    sps = 8'h80; step(); idle();
    chk("R6 nmi first", irq_line, NMI);
    // R8: enter NMI
    ack = 1; step(); ack = 0;
    chk("R8 status after entry", status_line, NMI);
    // R7: no request while active
    sps = 8'h02; ses = 8'h02; step(); idle();
    chk("R7 held off while active", irq_req, 0);
    // R10: return clears active
    ret = 1; ret_line = 3'd7; step(); idle();
    chk("R10 active cleared", active, 0);
    chk("R6 lowest enabled wins", irq_line, 1);
    irq_lvl = '0; step();

    // pseudo-random phase
    for (int c = 0; c < 4000; c++) begin
      irq_lvl = irq_lvl ^ N'($urandom & $urandom);
      sps = ($urandom % 6 == 0) ? N'($urandom & $urandom) : '0;
      spc = ($urandom % 5 == 0) ? N'($urandom & $urandom) : '0;
      ses = ($urandom % 7 == 0) ? N'($urandom) : '0;
      sec = ($urandom % 7 == 0) ? N'($urandom & $urandom) : '0;
      ack = ($urandom % 3 == 0) ? 1'b1 : (irq_req && ($urandom % 2 == 0));
      ret = (active != '0) ? ($urandom % 3 == 0) : ($urandom % 20 == 0);
      ret_line = IW'($urandom);
      if (ret && $urandom % 4 != 0)
        for (int i = 0; i < N; i++) if (active[i]) ret_line = IW'(i);
      step();
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule